// File: doc/BRIEF.md
# Aligned Clock-Enable Divider Bank

The block holds a bank of integer dividers. Each divider turns the block clock into a clock-enable strobe: one cycle high out of every R. Software programs each divider through a small register port. A divider register holds an enable flag and the value R-1. That write lands only in a shadow copy, so the running dividers are not disturbed while several registers are being rewritten.

A write of 1 to bit 0 of the command register starts a GO operation. A sequencer then moves through three states:

- **IDLE**: waiting for a command.
- **LOAD**: a single cycle in which the new settings are taken.
- **WAIT**: a fixed window of `GO_CYCLES` cycles.

The transitions are:

- **IDLE→LOAD**: taken on an accepted GO command.
- **LOAD→WAIT**: taken unconditionally after one cycle.
- **WAIT→IDLE**: taken when the window counter reaches its last value.

In the LOAD cycle, every divider whose bit is set in the alignment mask is restarted with its new setting on the same edge, so their strobes start in phase. The same happens to every divider that was idle. Any other running divider keeps its old ratio until its next terminal count, and then switches. The status register reports busy for the whole operation.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset every `clk_en` bit is 0 and every register reads 0, including the busy status.
- R2: The address map is as follows. Addresses 0..NUM_DIV-1 are divider shadows, with the enable in bit 15 and R-1 in bits [RATIO_W-1:0]; the other bits read 0. Address NUM_DIV is the command register, which always reads 0. Address NUM_DIV+1 is status, with busy in bit 0. Address NUM_DIV+2 is the alignment mask, where bit i selects divider i. The shadows and the mask read back as written.
- R3: Writes to the divider shadows or to the mask do not change any `clk_en` output until a GO is started.
- R4: A write to the command register with bit 0 set starts GO. A command write with bit 0 clear does nothing.
- R5: Busy reads 1 from the cycle after the GO write, for GO_CYCLES+1 cycles, and then reads 0.
- R6: An active, enabled divider with ratio R drives `clk_en` high for exactly one cycle in every R. With R=1, `clk_en` stays high.
- R7: An aligned divider, or one that was disabled, takes its new setting on the edge that ends the LOAD cycle. It is high in the k-th cycle after that edge (k=0 first) exactly when (k+1) mod R = 0, so all such dividers are in phase.
- R8: A running divider outside the mask emits its old-ratio strobes up to and including its first terminal count in or after the LOAD cycle. It then runs at the new ratio from that point, and the switch completes before busy falls.
- R9: A divider whose active enable is 0 holds `clk_en` low.
- R10: A GO command written while busy is 1 is ignored: busy timing and the outputs are unchanged.
- R11: GO applies the shadow values present when the GO write commits. Shadow writes made during busy take effect only at a later GO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| clk_en | output | NUM_DIV | One divided clock-enable strobe per divider |

## Verification
The LOAD cycle of a GO and the terminal count of a running, unaligned divider can fall in the same cycle. In that case the divider must take its new ratio at once, on that edge, rather than wait a full old period. The bench provokes this by reading the predicted pulse cycle from its own arithmetic model and timing the command write so that the LOAD cycle lands exactly on that pulse. The cycle-by-cycle comparison of every strobe then judges whether the old pulse is kept and whether the new period starts from that edge.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
    localparam int REG_W  = 16;
    localparam int EN_POS = 15;

    typedef enum logic [1:0] {
        GO_IDLE = 2'd0,
        GO_LOAD = 2'd1,
        GO_WAIT = 2'd2
    } go_state_t;
endpackage

// File: rtl/cdb_regs.sv
module cdb_regs
    import cdb_pkg::*;
#(
    parameter int NUM_DIV = 8,
    parameter int RATIO_W = 7,
    parameter int ADDR_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    input  logic                            busy,
    output logic [NUM_DIV-1:0]              sh_en,
    output logic [NUM_DIV-1:0][RATIO_W-1:0] sh_rm1,
    output logic [NUM_DIV-1:0]              align_mask,
    output logic                            go_req,
    output logic [REG_W-1:0]                rdata
);
    localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(NUM_DIV);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_DIV + 1);
    localparam logic [ADDR_W-1:0] ALN_A  = ADDR_W'(NUM_DIV + 2);

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_shadow
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_en[g]  <= 1'b0;
                sh_rm1[g] <= '0;
            end else if (wr_en && addr == ADDR_W'(g)) begin
                sh_en[g]  <= wdata[EN_POS];
                sh_rm1[g] <= wdata[RATIO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_mask <= '0;
        end else if (wr_en && addr == ALN_A) begin
            align_mask <= wdata[NUM_DIV-1:0];
        end
    end

    assign go_req = wr_en && (addr == CMD_A) && wdata[0];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata[EN_POS]        = sh_en[i];
                rdata[RATIO_W-1:0]   = sh_rm1[i];
            end
        end
        if (addr == STAT_A) rdata[0] = busy;
        if (addr == ALN_A)  rdata[NUM_DIV-1:0] = align_mask;
    end

    // Shadow settings move only on a register write.
    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(sh_rm1) && $stable(sh_en) && $stable(align_mask)));
endmodule

// File: rtl/cdb_go_fsm.sv
module cdb_go_fsm
    import cdb_pkg::*;
#(
    parameter int GO_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    output logic busy,
    output logic load_pulse
);
    localparam int WC_W = $clog2(GO_CYCLES + 1);
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(GO_CYCLES - 1);

    go_state_t st, st_nx;
    logic [WC_W-1:0] wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= GO_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              wcnt <= '0;
        else if (st == GO_LOAD)  wcnt <= '0;
        else if (st == GO_WAIT)  wcnt <= wcnt + 1'b1;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            GO_IDLE: if (go_req) st_nx = GO_LOAD;
            GO_LOAD: st_nx = GO_WAIT;
            GO_WAIT: if (wcnt == WC_LAST) st_nx = GO_IDLE;
            default: st_nx = GO_IDLE;
        endcase
    end

    always_comb begin
        busy       = (st != GO_IDLE);
        load_pulse = (st == GO_LOAD);
    end

    // Busy starts only after a command request.
    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go_req));
    // The load state is entered only from idle.
    assert_load_from_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GO_LOAD) |-> ($past(st) == GO_IDLE));
    // A request while busy never restarts the load.
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req) |=> (st != GO_LOAD));
    // The wait window never exceeds its length.
    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GO_WAIT) |-> (wcnt < WC_W'(GO_CYCLES)));
endmodule

// File: rtl/cdb_div.sv
module cdb_div #(
    parameter int RATIO_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_pulse,
    input  logic               busy,
    input  logic               align,
    input  logic               sh_en,
    input  logic [RATIO_W-1:0] sh_rm1,
    output logic               tick
);
    logic               act_en, stg_en, pend;
    logic [RATIO_W-1:0] act_rm1, stg_rm1, cnt;

    assign tick = act_en && (cnt == act_rm1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_en  <= 1'b0;
            stg_rm1 <= '0;
        end else if (load_pulse) begin
            stg_en  <= sh_en;
            stg_rm1 <= sh_rm1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_en  <= 1'b0;
            act_rm1 <= '0;
            cnt     <= '0;
            pend    <= 1'b0;
        end else if (load_pulse && (align || !act_en || tick)) begin
            act_en  <= sh_en;
            act_rm1 <= sh_rm1;
            cnt     <= '0;
            pend    <= 1'b0;
        end else if (pend && tick) begin
            act_en  <= stg_en;
            act_rm1 <= stg_rm1;
            cnt     <= '0;
            pend    <= 1'b0;
        end else begin
            if (load_pulse) pend <= 1'b1;
            if (act_en)     cnt  <= tick ? '0 : cnt + 1'b1;
        end
    end

    // Aligned dividers restart together on the load edge.
    assert_align_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && align) |=> (cnt == '0));
    // The counter stays inside the active period.
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |-> (cnt <= act_rm1));
    // A deferred switch has completed when the sequencer is idle.
    assert_pend_resolved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pend);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import cdb_pkg::*;
#(
    parameter int NUM_DIV   = 8,
    parameter int RATIO_W   = 7,
    parameter int ADDR_W    = 4,
    parameter int GO_CYCLES = (1 << RATIO_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic [NUM_DIV-1:0] clk_en
);
    logic [NUM_DIV-1:0]              sh_en, align_mask;
    logic [NUM_DIV-1:0][RATIO_W-1:0] sh_rm1;
    logic                            go_req, busy, load_pulse;

    cdb_regs #(.NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .sh_en(sh_en), .sh_rm1(sh_rm1), .align_mask(align_mask),
        .go_req(go_req), .rdata(rdata)
    );

    cdb_go_fsm #(.GO_CYCLES(GO_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req),
        .busy(busy), .load_pulse(load_pulse)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        cdb_div #(.RATIO_W(RATIO_W)) u_div (
            .clk(clk), .rst_n(rst_n), .load_pulse(load_pulse), .busy(busy),
            .align(align_mask[g]), .sh_en(sh_en[g]), .sh_rm1(sh_rm1[g]),
            .tick(clk_en[g])
        );
    end

    // With no active divider left after reset, every strobe is quiet.
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clk_en == '0));
endmodule

// File: tb/tb_clkdiv_bank.sv
`timescale 1ns/1ps
module tb_clkdiv_bank;
    localparam int ND = 8, RW = 7, AW = 4, GO = 128;
    localparam int CMD = ND, STAT = ND + 1, ALN = ND + 2;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = AW'(STAT);
    logic [15:0] wdata = '0, rdata;
    logic [ND-1:0] clk_en;

    clkdiv_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                     .wdata(wdata), .rdata(rdata), .clk_en(clk_en));

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vec = 0, fails = 0;
    bit done = 0;

    int  sh_R[ND];  bit sh_e[ND];  bit aln[ND];
    int  cb[ND], cR[ND], pb[ND], pR[ND], sw[ND];
    bit  ce[ND], pe[ND];
    int  go_w = -100000;

    function automatic bit f(bit e, int b, int r, int c);
        return e && (c >= b) && (((c - b + 1) % r) == 0);
    endfunction
    function automatic bit exp_out(int i, int c);
        return (c < sw[i]) ? f(pe[i], pb[i], pR[i], c) : f(ce[i], cb[i], cR[i], c);
    endfunction
    function automatic bit exp_busy(int c);
        return (c >= go_w + 1) && (c <= go_w + 1 + GO);
    endfunction

    task automatic step(string tag);
        @(negedge clk);
        for (int i = 0; i < ND; i++) begin
            vec++;
            if (clk_en[i] !== exp_out(i, cyc)) begin
                fails++;
                $display("FAIL %s clk_en[%0d] cycle %0d: got %b expected %b",
                         tag, i, cyc, clk_en[i], exp_out(i, cyc));
            end
        end
        if (!wr_en && addr == AW'(STAT)) begin
            vec++;
            if (rdata !== {15'b0, exp_busy(cyc)}) begin
                fails++;
                $display("FAIL R5 status cycle %0d: got %h expected %h",
                         cyc, rdata, {15'b0, exp_busy(cyc)});
            end
        end
    endtask

    task automatic run(int n, string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic wr(int a, logic [15:0] d, string tag);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        if (a < ND) begin sh_e[a] = d[15]; sh_R[a] = int'(d[RW-1:0]) + 1; end
        if (a == ALN) for (int i = 0; i < ND; i++) aln[i] = d[i];
        step(tag);
        wr_en = 1'b0; addr = AW'(STAT);
    endtask

    task automatic rd(int a, logic [15:0] e, string tag);
        addr = AW'(a);
        step(tag);
        vec++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s read addr %0d: got %h expected %h", tag, a, rdata, e);
        end
        addr = AW'(STAT);
    endtask

    task automatic do_go(string tag);
        int w = cyc;
        if (!exp_busy(w)) begin
            go_w = w;
            for (int i = 0; i < ND; i++) begin
                pb[i] = cb[i]; pR[i] = cR[i]; pe[i] = ce[i];
                if (aln[i] || !ce[i]) sw[i] = w + 2;
                else begin
                    int d = (w + 2 - cb[i]) % cR[i];
                    sw[i] = (d == 0) ? w + 2 : w + 2 + cR[i] - d;
                end
                cb[i] = sw[i]; cR[i] = sh_R[i]; ce[i] = sh_e[i];
            end
        end
        wr(CMD, 16'h0001, tag);
    endtask

    function automatic logic [15:0] dreg(bit e, int r);
        return {e, 8'b0, 7'(r - 1)};
    endfunction

    initial begin
        for (int i = 0; i < ND; i++) begin
            sh_R[i] = 1; sh_e[i] = 0; aln[i] = 0;
            cb[i] = 0; cR[i] = 1; pb[i] = 0; pR[i] = 1; sw[i] = 0; ce[i] = 0; pe[i] = 0;
        end
        repeat (3) @(negedge clk);
        vec++;
        if (clk_en !== '0) begin
            fails++; $display("FAIL R1 clk_en in reset: got %h expected 0", clk_en);
        end
        rst_n = 1'b1;
        // R1: reset contents
        for (int a = 0; a <= ALN; a++) rd(a, 16'h0000, "R1");
        run(5, "R1");

        // Config 0: ratios include 3, 5, 64; divider 6 disabled (R9)
        begin
            int rr[ND] = '{4, 3, 2, 1, 5, 7, 9, 64};
            for (int i = 0; i < ND; i++) wr(i, dreg(i != 6, rr[i]), "R3");
            wr(ALN, 16'h0092, "R3");
            for (int i = 0; i < ND; i++) rd(i, dreg(i != 6, rr[i]), "R2");
            rd(ALN, 16'h0092, "R2");
            rd(CMD, 16'h0000, "R2");
        end
        run(60, "R3");                 // nothing active before GO
        wr(CMD, 16'h0002, "R4");       // bit 0 clear: no GO
        run(20, "R4");
        do_go("R7");
        run(400, "R6");

        // R3 / R8: shadow changes held until GO; unaligned switch deferred
        wr(0, dreg(1, 6), "R3");
        wr(1, dreg(1, 5), "R3");
        wr(7, dreg(1, 3), "R3");
        wr(3, dreg(0, 1), "R9");
        run(100, "R3");
        do_go("R8");
        run(400, "R8");

        // R10 / R11: GO while busy ignored, shadow write during busy deferred
        wr(2, dreg(1, 11), "R11");
        do_go("R10");
        run(20, "R10");
        wr(5, dreg(1, 13), "R11");
        do_go("R10");
        run(300, "R10");
        do_go("R11");
        run(300, "R11");

        // R8: LOAD cycle coincides with terminal count of unaligned divider 0
        begin
            int c;
            wr(ALN, 16'h00F0, "R8");
            wr(0, dreg(1, 9), "R8");
            c = cyc + 3;
            while (!exp_out(0, c)) c++;
            while (cyc < c - 1) step("R8");
            do_go("R8");
            run(300, "R8");
        end

        // Sweep of computed configurations
        for (int s = 1; s <= 5; s++) begin
            for (int i = 0; i < ND; i++)
                wr(i, dreg(((i + s) % 5) != 0, 1 + ((i * 29 + s * 41) % 128)), "R6");
            wr(ALN, 16'((s * 91) & 8'hFF), "R7");
            do_go("R7");
            run(420, "R8");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
            $finish;
        end
    end
endmodule